// File: doc/BRIEF.md
# Dual-Mode Bus Transition Controller

This block decides which of two protocols owns a shared serial data line. After reset it grants the line to a free-running streamer that shifts out memory contents on each edge of a slow stream clock. A falling edge on the two-wire bus clock pauses the streamer and opens a tentative window. During that window the block counts rising edges of the stream clock that arrive while the bus clock rests high.

If the two-wire slave decoder reports a matching device address during the window, the block locks into bidirectional mode and stays there until reset. If the count reaches its limit first, the block hands the line back to the streamer. It also sends one restart pulse so that streaming begins again from the most significant bit of the first location.

In bidirectional mode the stream clock is no longer a clock. Its level becomes a write qualifier: high permits writes and low blocks them.

Top module: `dual_mode_arbiter`

## Requirements
- R1: After reset `mode_o` is 2'b00 (streaming), `restart_o` is 0 and `write_ok_o` is 0. The mode encoding is 2'b00 streaming, 2'b01 transition, 2'b10 bidirectional.
- R2: In streaming mode the mode stays 2'b00 while `bus_clk_i` stays high, whatever `strm_clk_i` and `addr_hit_i` do.
- R3: A high-to-low change of `bus_clk_i` in streaming mode sets `mode_o` to 2'b01 at the clock edge where the low level is first sampled.
- R4: Each high-to-low change of `bus_clk_i` in transition mode clears the pulse count, so a full fresh run of pulses is then needed to revert.
- R5: In transition mode, rising edges of `strm_clk_i` sampled while `bus_clk_i` is high are counted. Edges sampled while `bus_clk_i` is low are not counted. At the edge that registers the 128th counted pulse, `mode_o` returns to 2'b00 and `restart_o` is high for exactly that one cycle.
- R6: `addr_hit_i` high in transition mode sets `mode_o` to 2'b10 at that edge.
- R7: Once `mode_o` is 2'b10, only reset changes it. Bus clock edges, stream pulses and address pulses have no effect on it.
- R8: `write_ok_o` is registered. It equals bidirectional mode AND the `strm_clk_i` level sampled at the same edge, and it is 0 in every other mode.
- R9: If `addr_hit_i` arrives at the same edge as the 128th counted pulse, the revert wins and `mode_o` becomes 2'b00.
- R10: `addr_hit_i` in streaming mode is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_clk_i | input | 1 | Synchronised two-wire bus clock level |
| strm_clk_i | input | 1 | Synchronised stream clock level |
| addr_hit_i | input | 1 | One-cycle pulse: slave decoder matched the device address |
| mode_o | output | 2 | Current mode (00 stream, 01 transition, 10 bidirectional) |
| restart_o | output | 1 | One-cycle pulse telling the streamer to restart from the first bit |
| write_ok_o | output | 1 | Write permission qualifier for bidirectional mode |

## Verification
Every output is registered. A change on an input sampled at one rising edge therefore appears on `mode_o`, `restart_o` and `write_ok_o` right after that same edge, with no further latency. The revert pulse and the address lock are both decided at the edge that sees the deciding input. The bench drives inputs on falling edges and keeps a behavioural model that advances on each rising edge. It compares all three outputs at the following falling edge, half a period after they are due. Directed checks for the counting boundary, the count clear and the address-versus-revert collision are also read at that falling edge.

// File: rtl/dual_mode_pkg.sv
package dual_mode_pkg;
  typedef enum logic [1:0] {
    MODE_STREAM = 2'b00,
    MODE_TRANS  = 2'b01,
    MODE_BIDIR  = 2'b10
  } mode_t;

  localparam int unsigned REVERT_PULSES = 128;
endpackage

// File: rtl/dm_edge_sense.sv
module dm_edge_sense #(
  parameter int unsigned W = 2,
  parameter logic [W-1:0] IDLE_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] level_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= IDLE_VAL;
    else        prev_q <= level_i;
  end

  for (genvar g = 0; g < W; g++) begin : g_edge
    assign rise_o[g] = ~prev_q[g] &  level_i[g];
    assign fall_o[g] =  prev_q[g] & ~level_i[g];
  end
endmodule

// File: rtl/dm_pulse_counter.sv
module dm_pulse_counter #(
  parameter int unsigned LIMIT = 128,
  localparam int unsigned CW = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_i,
  input  logic          incr_i,
  output logic          hit_o,
  output logic [CW-1:0] count_o
);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);
  localparam logic [CW-1:0] TOP  = CW'(LIMIT);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign hit_o  = incr_i & ~clear_i & (cnt_q == LAST);
  assign cnt_en = clear_i | (incr_i & (cnt_q != TOP));

  always_comb begin
    if (clear_i) cnt_d = '0;
    else         cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/dm_mode_fsm.sv
module dm_mode_fsm
  import dual_mode_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  bus_fall_i,
  input  logic  bus_lvl_i,
  input  logic  strm_rise_i,
  input  logic  strm_lvl_i,
  input  logic  addr_hit_i,
  input  logic  cnt_hit_i,
  output logic  cnt_clear_o,
  output logic  cnt_incr_o,
  output mode_t mode_o,
  output logic  restart_o,
  output logic  write_ok_o
);
  mode_t state_q, state_d;
  logic  restart_d, wok_d;

  assign cnt_clear_o = bus_fall_i & (state_q != MODE_BIDIR);
  assign cnt_incr_o  = (state_q == MODE_TRANS) & strm_rise_i & bus_lvl_i;

  always_comb begin
    state_d   = state_q;
    restart_d = 1'b0;
    unique case (state_q)
      MODE_STREAM: begin
        if (bus_fall_i) state_d = MODE_TRANS;
      end
      MODE_TRANS: begin
        if (cnt_hit_i) begin
          state_d   = MODE_STREAM;
          restart_d = 1'b1;
        end else if (addr_hit_i) begin
          state_d = MODE_BIDIR;
        end
      end
      MODE_BIDIR: state_d = MODE_BIDIR;
      default:    state_d = MODE_STREAM;
    endcase
    wok_d = (state_d == MODE_BIDIR) & strm_lvl_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= MODE_STREAM;
      restart_o  <= 1'b0;
      write_ok_o <= 1'b0;
    end else begin
      state_q    <= state_d;
      restart_o  <= restart_d;
      write_ok_o <= wok_d;
    end
  end

  assign mode_o = state_q;
endmodule

// File: rtl/dual_mode_arbiter.sv
module dual_mode_arbiter
  import dual_mode_pkg::*;
#(
  parameter int unsigned REVERT_CNT = REVERT_PULSES
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_clk_i,
  input  logic       strm_clk_i,
  input  logic       addr_hit_i,
  output logic [1:0] mode_o,
  output logic       restart_o,
  output logic       write_ok_o
);
  localparam int unsigned CW = $clog2(REVERT_CNT + 1);

  logic [1:0]    rise_w, fall_w;
  logic          cnt_clear, cnt_incr, cnt_hit;
  logic [CW-1:0] cnt_val;
  mode_t         mode_w;

  dm_edge_sense #(.W(2), .IDLE_VAL(2'b11)) u_edges (
    .clk     (clk),
    .rst_n   (rst_n),
    .level_i ({strm_clk_i, bus_clk_i}),
    .rise_o  (rise_w),
    .fall_o  (fall_w)
  );

  dm_pulse_counter #(.LIMIT(REVERT_CNT)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (cnt_clear),
    .incr_i  (cnt_incr),
    .hit_o   (cnt_hit),
    .count_o (cnt_val)
  );

  dm_mode_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_fall_i  (fall_w[0]),
    .bus_lvl_i   (bus_clk_i),
    .strm_rise_i (rise_w[1]),
    .strm_lvl_i  (strm_clk_i),
    .addr_hit_i  (addr_hit_i),
    .cnt_hit_i   (cnt_hit),
    .cnt_clear_o (cnt_clear),
    .cnt_incr_o  (cnt_incr),
    .mode_o      (mode_w),
    .restart_o   (restart_o),
    .write_ok_o  (write_ok_o)
  );

  assign mode_o = mode_w;
endmodule

// File: rtl/dual_mode_arbiter_chk.sv
module dual_mode_arbiter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_clk_i,
  input logic       addr_hit_i,
  input logic [1:0] mode_o,
  input logic       restart_o,
  input logic       write_ok_o
);
  assert_stream_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'b00 && bus_clk_i) |=> (mode_o == 2'b00));

  assert_fall_enters_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'b00 && !bus_clk_i) |=> (mode_o == 2'b01));

  assert_restart_in_stream_R5: assert property (@(posedge clk) disable iff (!rst_n)
    restart_o |-> (mode_o == 2'b00));

  assert_restart_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    restart_o |=> !restart_o);

  assert_bidir_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'b10) |=> (mode_o == 2'b10));

  assert_wok_only_bidir_R8: assert property (@(posedge clk) disable iff (!rst_n)
    write_ok_o |-> (mode_o == 2'b10));

  assert_addr_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'b00 && addr_hit_i) |=> (mode_o != 2'b10));

  always_comb begin
    assert_legal_mode_R1: assert (!rst_n || mode_o != 2'b11);
  end
endmodule

bind dual_mode_arbiter dual_mode_arbiter_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_clk_i  (bus_clk_i),
  .addr_hit_i (addr_hit_i),
  .mode_o     (mode_o),
  .restart_o  (restart_o),
  .write_ok_o (write_ok_o)
);

// File: tb/dual_mode_arbiter_tb_top.sv
module dual_mode_arbiter_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_clk = 1'b1;
  logic       strm_clk = 1'b0;
  logic       addr_hit = 1'b0;
  logic [1:0] mode;
  logic       restart, wok;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  dual_mode_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .bus_clk_i(bus_clk), .strm_clk_i(strm_clk),
    .addr_hit_i(addr_hit), .mode_o(mode), .restart_o(restart), .write_ok_o(wok)
  );

  // behavioural reference
  int m_state, m_cnt;
  bit m_pb, m_ps, m_rs, m_wa;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_cnt = 0; m_pb = 1; m_ps = 1; m_rs = 0; m_wa = 0;
    end else begin
      bit fall, rise, rev;
      fall = m_pb && !bus_clk;
      rise = !m_ps && strm_clk;
      rev  = 0;
      if (m_state == 0) begin
        if (fall) begin m_state = 1; m_cnt = 0; end
      end else if (m_state == 1) begin
        if (fall) m_cnt = 0;
        else if (rise && bus_clk) begin
          if (m_cnt + 1 >= 128) rev = 1;
          else m_cnt = m_cnt + 1;
        end
        if (rev) m_state = 0;
        else if (addr_hit) m_state = 2;
      end
      m_rs = rev;
      m_wa = (m_state == 2) && strm_clk;
      m_pb = bus_clk;
      m_ps = strm_clk;
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      n_cmp++;
      if (mode !== 2'(m_state) || restart !== m_rs || wok !== m_wa) begin
        n_bad++;
        $display("FAIL R2/R3/R5/R6/R8 model compare: mode=%0d rst=%0d wok=%0d expected %0d %0d %0d",
                 mode, restart, wok, m_state, m_rs, m_wa);
      end
    end
    if (cycles > 150000) begin
      n_bad++;
      $display("FAIL watchdog: cycles=%0d expected < 150000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // one stream pulse: high one cycle, low one cycle
  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      strm_clk = 1'b1; tick();
      strm_clk = 1'b0; tick();
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; bus_clk = 1'b1; strm_clk = 1'b0; addr_hit = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick();
  endtask

  initial begin
    do_reset();
    check(mode == 2'b00, "R1 mode", mode, 0);
    check(restart == 1'b0, "R1 restart", restart, 0);
    check(wok == 1'b0, "R1 write_ok", wok, 0);

    // R2 / R10
    pulse(200);
    check(mode == 2'b00, "R2 stream hold", mode, 0);
    addr_hit = 1'b1; tick(); addr_hit = 1'b0; tick();
    check(mode == 2'b00, "R10 addr ignored", mode, 0);

    // R3
    bus_clk = 1'b0; tick();
    check(mode == 2'b01, "R3 enter transition", mode, 1);
    bus_clk = 1'b1; tick();

    // R5: pulses with bus low are not counted
    bus_clk = 1'b0; pulse(1); bus_clk = 1'b1; tick();
    pulse(100);
    // R4: fall clears count
    bus_clk = 1'b0; tick(); bus_clk = 1'b1; tick();
    pulse(127);
    check(mode == 2'b01, "R4 count cleared", mode, 1);
    strm_clk = 1'b1; tick();
    check(mode == 2'b00, "R5 revert at 128", mode, 0);
    check(restart == 1'b1, "R5 restart pulse", restart, 1);
    strm_clk = 1'b0; tick();
    check(restart == 1'b0, "R5 restart one cycle", restart, 0);

    // R6 / R8 / R7
    bus_clk = 1'b0; tick(); bus_clk = 1'b1; tick();
    pulse(5);
    addr_hit = 1'b1; tick(); addr_hit = 1'b0;
    check(mode == 2'b10, "R6 lock bidir", mode, 2);
    strm_clk = 1'b1; tick();
    check(wok == 1'b1, "R8 write allowed", wok, 1);
    strm_clk = 1'b0; tick();
    check(wok == 1'b0, "R8 write blocked", wok, 0);
    for (int k = 0; k < 3; k++) begin
      bus_clk = 1'b0; tick(); bus_clk = 1'b1; tick();
    end
    pulse(200);
    addr_hit = 1'b1; tick(); addr_hit = 1'b0; tick();
    check(mode == 2'b10, "R7 bidir permanent", mode, 2);
    do_reset();
    check(mode == 2'b00, "R7 reset leaves bidir", mode, 0);

    // R9 collision
    bus_clk = 1'b0; tick(); bus_clk = 1'b1; tick();
    pulse(127);
    strm_clk = 1'b1; addr_hit = 1'b1; tick();
    addr_hit = 1'b0;
    check(mode == 2'b00, "R9 revert wins", mode, 0);
    check(restart == 1'b1, "R9 restart", restart, 1);
    strm_clk = 1'b0; tick(2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule